// File: doc/BRIEF.md
# Coupled-Integrator Quadrature Oscillator

This block is a digitally controlled oscillator for a phase-locked loop. It produces a sine and a cosine without a lookup table or an iterative rotation engine. Two discrete integrators are cross-coupled: each one is driven by the other scaled by the frequency step. The pair oscillates at the commanded angular frequency, and saturation of each integrator keeps the amplitude bounded.

A separate phase register integrates the same frequency step, rescaled from Q15 to Q12. It is forced back to zero whenever the sine output falls from non-negative to negative, so the phase stays aligned with the oscillator's own waveform. If no realignment arrives, the phase clips at 2π instead of wrapping.

The host asserts a one-cycle sample strobe together with the frequency step, which is the angular frequency times the sample period. The block updates all its state on that clock edge and raises a one-cycle valid flag during the following cycle. Between strobes every output holds.

Top module: `quad_dco`

## Requirements
- R1: While reset is high and after it is released, before any strobe, the sine output is 0, the cosine output is 32440 (0.99 in Q15), the phase is 0 and valid is low.
- R2: On a strobe, the new sine is the old sine plus round(step × old cosine / 2^15), where round adds 2^14 and then shifts right arithmetically by 15. The result is then saturated.
- R3: On a strobe, the new cosine is the old cosine minus round(step × old sine / 2^15), using the same rounding. Both R2 and R3 use the values held before the strobe.
- R4: After every update, sine and cosine are each clamped to the closed range −32440 to +32440.
- R5: On a strobe with no realignment, the phase (Q12, signed 16-bit) grows by the step rescaled to Q12, which is (step + 4) shifted right arithmetically by 3.
- R6: When the old sine has its sign bit clear and the new sine has its sign bit set, the phase becomes 0 on that same strobe. This takes priority over R5 and R7.
- R7: The phase never leaves 0 to 25736 (2π in Q12). A sum above 25736 is held at 25736, and a sum below 0 is held at 0.
- R8: Valid is high for exactly the cycle after each strobe cycle and low otherwise. Without a strobe, sine, cosine and phase do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | 1 | One-cycle sample strobe |
| step_i | input | DW (16) | Signed Q15 angular frequency times sample period |
| sin_o | output | DW (16) | Signed Q15 sine |
| cos_o | output | DW (16) | Signed Q15 cosine |
| phase_o | output | PW (16) | Signed Q12 phase, 0 to 2π |
| valid_o | output | 1 | High the cycle after a strobe |

## Verification
The bench sweeps step values from zero through the full positive and negative extremes, including a step large enough to drive the forward-Euler pair into its clamps. A design that clamped at full scale, or that let the cosine update see the freshly written sine, would diverge from the bench model on the first affected sample. A long low-frequency run, whose Q12 rescaling rounds up, forces the phase into its 2π ceiling before the next falling crossing; a wrapping accumulator would drop to a small value there. Negative steps drive the phase into its zero floor. Idle cycles between strobes catch a valid flag that lingers or state that drifts without a strobe.

// File: rtl/qdco_pkg.sv
package qdco_pkg;

    // Wide signed accumulator used for all intermediate arithmetic
    localparam int ACC_W = 48;
    typedef logic signed [ACC_W-1:0] acc_t;

    // Phase register decision for one sample
    typedef enum logic [1:0] {
        PH_ADVANCE = 2'd0,
        PH_REALIGN = 2'd1,
        PH_CLIP_HI = 2'd2,
        PH_CLIP_LO = 2'd3
    } ph_action_t;

    // Arithmetic right shift with round-half-up
    function automatic acc_t round_shr(input acc_t v, input int sh);
        acc_t bias;
        if (sh <= 0) begin
            return v;
        end
        bias = acc_t'(1) <<< (sh - 1);
        return (v + bias) >>> sh;
    endfunction

    // Saturate v into [lo, hi]
    function automatic acc_t clamp_range(input acc_t v, input acc_t lo, input acc_t hi);
        if (v > hi) begin
            return hi;
        end
        if (v < lo) begin
            return lo;
        end
        return v;
    endfunction

endpackage

// File: rtl/qdco_osc_core.sv
module qdco_osc_core
    import qdco_pkg::*;
#(
    parameter int DW      = 16,
    parameter int FRAC    = 15,
    parameter int AMP_LIM = 32440
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic signed [DW-1:0] step,
    output logic signed [DW-1:0] sin_q,
    output logic signed [DW-1:0] cos_q,
    output logic signed [DW-1:0] sin_nxt
);

    typedef struct packed {
        logic signed [DW-1:0] s;
        logic signed [DW-1:0] c;
    } osc_state_t;

    localparam acc_t AMP_HI = acc_t'(AMP_LIM);
    localparam acc_t AMP_LO = -acc_t'(AMP_LIM);

    osc_state_t cur, nxt;
    acc_t       prod_sc, prod_cs;
    acc_t       ds, dc;
    acc_t       sum_s, sum_c;

    always_comb begin
        // Both products read the state held before this sample
        prod_sc = acc_t'(step) * acc_t'(cur.c);
        prod_cs = acc_t'(step) * acc_t'(cur.s);
        ds      = round_shr(prod_sc, FRAC);
        dc      = round_shr(prod_cs, FRAC);
        sum_s   = clamp_range(acc_t'(cur.s) + ds, AMP_LO, AMP_HI);
        sum_c   = clamp_range(acc_t'(cur.c) - dc, AMP_LO, AMP_HI);
        nxt.s   = sum_s[DW-1:0];
        nxt.c   = sum_c[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.s <= '0;
            cur.c <= DW'(AMP_LIM);
        end else if (en) begin
            cur <= nxt;
        end
    end

    assign sin_q   = cur.s;
    assign cos_q   = cur.c;
    assign sin_nxt = nxt.s;

    AST_SIN_BOUND: assert property (@(posedge clk) disable iff (rst)
        (sin_q <= DW'(AMP_LIM)) && (sin_q >= -DW'(AMP_LIM))); // R4
    AST_COS_BOUND: assert property (@(posedge clk) disable iff (rst)
        (cos_q <= DW'(AMP_LIM)) && (cos_q >= -DW'(AMP_LIM))); // R4
    AST_OSC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(sin_q) && $stable(cos_q)); // R8

endmodule

// File: rtl/qdco_phase_acc.sv
module qdco_phase_acc
    import qdco_pkg::*;
#(
    parameter int DW      = 16,
    parameter int FRAC    = 15,
    parameter int PW      = 16,
    parameter int PH_FRAC = 12,
    parameter int PH_MAX  = 25736
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic signed [DW-1:0] step,
    input  logic signed [DW-1:0] sin_cur,
    input  logic signed [DW-1:0] sin_nxt,
    output logic signed [PW-1:0] phase_q
);

    localparam int   SHIFT  = FRAC - PH_FRAC;
    localparam acc_t PH_TOP = acc_t'(PH_MAX);

    acc_t       inc;
    acc_t       sum;
    acc_t       res;
    ph_action_t act;
    logic       fall_cross;

    always_comb begin
        inc        = round_shr(acc_t'(step), SHIFT);
        sum        = acc_t'(phase_q) + inc;
        fall_cross = !sin_cur[DW-1] && sin_nxt[DW-1];
        if (fall_cross) begin
            act = PH_REALIGN;
        end else if (sum > PH_TOP) begin
            act = PH_CLIP_HI;
        end else if (sum < 0) begin
            act = PH_CLIP_LO;
        end else begin
            act = PH_ADVANCE;
        end
        case (act)
            PH_REALIGN: res = '0;
            PH_CLIP_HI: res = PH_TOP;
            PH_CLIP_LO: res = '0;
            default:    res = sum;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (en) begin
            phase_q <= res[PW-1:0];
        end
    end

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase_q >= 0) && (phase_q <= PW'(PH_MAX))); // R7
    AST_ZC_REALIGN: assert property (@(posedge clk) disable iff (rst)
        (en && !sin_cur[DW-1] && sin_nxt[DW-1]) |=> (phase_q == '0)); // R6
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(phase_q)); // R8

endmodule

// File: rtl/quad_dco.sv
module quad_dco
    import qdco_pkg::*;
#(
    parameter int DW      = 16,
    parameter int FRAC    = 15,
    parameter int PW      = 16,
    parameter int PH_FRAC = 12,
    parameter int AMP_LIM = 32440,
    parameter int PH_MAX  = 25736
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample_i,
    input  logic signed [DW-1:0] step_i,
    output logic signed [DW-1:0] sin_o,
    output logic signed [DW-1:0] cos_o,
    output logic signed [PW-1:0] phase_o,
    output logic                 valid_o
);

    logic signed [DW-1:0] sin_cur;
    logic signed [DW-1:0] sin_nxt;

    qdco_osc_core #(
        .DW      (DW),
        .FRAC    (FRAC),
        .AMP_LIM (AMP_LIM)
    ) i_osc (
        .clk     (clk),
        .rst     (rst),
        .en      (sample_i),
        .step    (step_i),
        .sin_q   (sin_cur),
        .cos_q   (cos_o),
        .sin_nxt (sin_nxt)
    );

    qdco_phase_acc #(
        .DW      (DW),
        .FRAC    (FRAC),
        .PW      (PW),
        .PH_FRAC (PH_FRAC),
        .PH_MAX  (PH_MAX)
    ) i_phase (
        .clk     (clk),
        .rst     (rst),
        .en      (sample_i),
        .step    (step_i),
        .sin_cur (sin_cur),
        .sin_nxt (sin_nxt),
        .phase_q (phase_o)
    );

    assign sin_o = sin_cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
        end else begin
            valid_o <= sample_i;
        end
    end

    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        sample_i |=> valid_o); // R8
    AST_VALID_QUIET: assert property (@(posedge clk) disable iff (rst)
        !sample_i |=> !valid_o); // R8

endmodule

// File: tb/test_quad_dco.sv
module test_quad_dco;

    localparam int AMP   = 32440;
    localparam int PHTOP = 25736;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               sample_i = 1'b0;
    logic signed [15:0] step_i = '0;
    logic signed [15:0] sin_o, cos_o, phase_o;
    logic               valid_o;

    int checks = 0;
    int errors = 0;
    int m_sin, m_cos, m_ph;
    bit saw_top, saw_floor, saw_clamp, saw_realign;

    always #10 clk = ~clk;

    quad_dco i_quad_dco (
        .clk      (clk),
        .rst      (rst),
        .sample_i (sample_i),
        .step_i   (step_i),
        .sin_o    (sin_o),
        .cos_o    (cos_o),
        .phase_o  (phase_o),
        .valid_o  (valid_o)
    );

    function automatic int clampi(input int v, input int lo, input int hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Bench model of one sample
    task automatic model_step(input int st);
        int ns, nc, sum;
        ns  = clampi(m_sin + ((st * m_cos + 16384) >>> 15), -AMP, AMP);
        nc  = clampi(m_cos - ((st * m_sin + 16384) >>> 15), -AMP, AMP);
        if (ns == AMP || ns == -AMP || nc == AMP || nc == -AMP) saw_clamp = 1;
        sum = m_ph + ((st + 4) >>> 3);
        if (m_sin >= 0 && ns < 0) begin
            m_ph = 0;
            saw_realign = 1;
        end else if (sum > PHTOP) begin
            m_ph = PHTOP;
            saw_top = 1;
        end else if (sum < 0) begin
            m_ph = 0;
            saw_floor = 1;
        end else begin
            m_ph = sum;
        end
        m_sin = ns;
        m_cos = nc;
    endtask

    task automatic run_sweep(input int st, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            sample_i = 1'b1;
            step_i   = 16'(st);
            model_step(st);
            @(negedge clk);
            sample_i = 1'b0;
            chk("R8 valid", int'(valid_o), 1);
            chk("R2 sine", int'(sin_o), m_sin);
            chk("R3 cosine", int'(cos_o), m_cos);
            chk("R5/R6/R7 phase", int'(phase_o), m_ph);
            step_i = 16'sh5A5A;
            @(negedge clk);
            chk("R8 valid idle", int'(valid_o), 0);
            chk("R8 hold", int'(sin_o) ^ int'(cos_o) ^ int'(phase_o), m_sin ^ m_cos ^ m_ph);
        end
    endtask

    task automatic run_all();
        m_sin = 0; m_cos = AMP; m_ph = 0;
        repeat (3) @(negedge clk);
        chk("R1 sin", int'(sin_o), 0);
        chk("R1 cos", int'(cos_o), AMP);
        chk("R1 phase", int'(phase_o), 0);
        chk("R1 valid", int'(valid_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release cos", int'(cos_o), AMP);
        run_sweep(0, 20);
        run_sweep(205, 400);
        run_sweep(12, 36000);
        run_sweep(-1024, 400);
        run_sweep(8000, 400);
        run_sweep(32767, 300);
        run_sweep(-32768, 300);
        run_sweep(1, 200);
        chk("R7 ceiling reached", int'(saw_top), 1);
        chk("R7 floor reached", int'(saw_floor), 1);
        chk("R4 clamp reached", int'(saw_clamp), 1);
        chk("R6 realign seen", int'(saw_realign), 1);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                chk("watchdog", 1, 0);
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule